// File: doc/BRIEF.md
# Volts-per-Hertz Three-Phase Sine Reference

This block produces the three sinusoidal reference streams that a multilevel modulator compares against its carriers. A single phase accumulator advances by a commanded increment once per sample period. Three lanes read a quarter-wave sine table at phase points spaced a third of a turn apart. Each lane multiplies its table value by a shared amplitude and rounds the product to a signed output.

The amplitude follows the frequency command through a programmable volts-per-hertz slope, so machine flux stays constant at low speed. Once the slope reaches the rated amplitude limit, the amplitude stops rising and only frequency increases beyond that point (the field-weakening region). New command, slope and limit values are taken only when the accumulator rolls over, or at once while the generator is stopped, so the waveform never jumps mid-cycle.

Top module: `vhzSineRef`

## Requirements
- R1: While reset (active-low, asynchronous) is asserted, all three outputs are zero and the valid strobe is low; the accumulator, active increment and amplitude restart at zero.
- R2: The valid strobe is a single-cycle pulse repeating every SAMPLE_DIV (default 4) clock cycles; the outputs change only in a cycle where the strobe is high.
- R3: Below the knee, the amplitude equals floor(freqCmd × vfRatio / 2^16), where vfRatio is unsigned with 16 fraction bits, so the peak output is linear in the command.
- R4: When that product exceeds ampLimit, the amplitude is clamped to ampLimit.
- R5: On each sample the 24-bit accumulator advances by the active increment modulo 2^24. Phase A then equals round(amp × sin(2π(k+0.5)/1024)) within 2 LSB, with k the accumulator's top 10 bits.
- R6: Phase B uses the accumulator minus 5592405 and phase C the accumulator minus 11184811 (modulo 2^24), so each lags the one before by 120°; the sum of the three samples stays within amp/64 + 4 of zero.
- R7: A new command, slope or limit is latched only on a sample whose accumulator step carries past 2^24, or on any sample while the active increment is zero. On that sample the accumulator still steps by the old increment, but the output already uses the new amplitude.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| freqCmd | input | 16 | Phase increment per sample (output frequency command) |
| vfRatio | input | 16 | Volts-per-hertz slope, unsigned, 16 fraction bits |
| ampLimit | input | 15 | Rated amplitude ceiling |
| phaseA | output | 16 | Signed reference, phase A |
| phaseB | output | 16 | Signed reference, phase B (lags A by 120°) |
| phaseC | output | 16 | Signed reference, phase C (lags B by 120°) |
| sampleValid | output | 1 | One-cycle pulse marking a new sample |

## Verification
The bounds on sample magnitude and on the three-phase sum rely on the amplitude holding still from the sample's load edge until its output edge. That holds only when SAMPLE_DIV is at least 3. The sum bound also assumes that the table quantisation to 1024 phase bins sets the error floor. The stimulus changes the command, slope and limit only in the cycle right after a valid pulse, well ahead of the next advance, so the bench's sample-by-sample model sees the same inputs the design latched. Amplitudes stay within the 15-bit limit port, and increments stay large enough that each rollover arrives within a few thousand cycles.

// File: rtl/vhzPkg.sv
package vhzPkg;
  typedef struct packed {
    logic advance;  // accumulator steps on this edge
    logic loadCmd;  // command, slope and limit latched on this edge
    logic stage1;   // lane table lookup registers
    logic stage2;   // lane multiply/round output registers
  } vhzStrobes_t;
endpackage

// File: rtl/vhzCtrl.sv
module vhzCtrl import vhzPkg::*; #(
  parameter int SAMPLE_DIV = 4
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        wrapNext,
  input  logic        incZero,
  output vhzStrobes_t strobes,
  output logic        sampleValid
);
  localparam int CNT_W = (SAMPLE_DIV > 1) ? $clog2(SAMPLE_DIV) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(SAMPLE_DIV - 1);

  logic [CNT_W-1:0] divCnt;
  logic tick;
  logic s1Q, s2Q;

  assign tick = (divCnt == CNT_LAST);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divCnt      <= '0;
      s1Q         <= 1'b0;
      s2Q         <= 1'b0;
      sampleValid <= 1'b0;
    end else begin
      divCnt      <= tick ? '0 : divCnt + 1'b1;
      s1Q         <= tick;
      s2Q         <= s1Q;
      sampleValid <= s2Q;
    end
  end

  always_comb begin
    strobes.advance = tick;
    strobes.loadCmd = tick & (wrapNext | incZero);
    strobes.stage1  = s1Q;
    strobes.stage2  = s2Q;
  end
endmodule

// File: rtl/vhzSineLane.sv
module vhzSineLane import vhzPkg::*; #(
  parameter int ACC_W  = 24,
  parameter int LUT_AW = 8,
  parameter int TBL_W  = 16,
  parameter int AMP_W  = 15
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  vhzStrobes_t             strobes,
  input  logic [ACC_W-1:0]        phase,
  input  logic [AMP_W-1:0]        amp,
  output logic signed [AMP_W:0]   sampleOut
);
  localparam int LUT_N  = 1 << LUT_AW;
  localparam int PROD_W = TBL_W + AMP_W + 1;
  localparam logic [PROD_W-1:0] HALF_LSB = PROD_W'(1) << (TBL_W - 1);

  function automatic logic [TBL_W-1:0] quarterPoint(input int i);
    real ang;
    real val;
    ang = 1.5707963267948966 * (real'(i) + 0.5) / real'(LUT_N);
    val = $sin(ang) * real'((1 << TBL_W) - 1);
    return TBL_W'($rtoi(val + 0.5));
  endfunction

  logic [TBL_W-1:0] lut [LUT_N];
  for (genvar i = 0; i < LUT_N; i++) begin : g_lut
    localparam logic [TBL_W-1:0] POINT = quarterPoint(i);
    assign lut[i] = POINT;
  end

  logic [LUT_AW+1:0] phaseTop;
  logic [LUT_AW-1:0] addr;
  logic [TBL_W-1:0]  magQ;
  logic              negQ;
  logic [PROD_W-1:0] scaled;
  logic [AMP_W-1:0]  rounded;

  assign phaseTop = (LUT_AW+2)'(phase >> (ACC_W - LUT_AW - 2));
  // odd quadrants read the table backwards; lower half-turn is negative
  assign addr     = phaseTop[LUT_AW] ? ~phaseTop[LUT_AW-1:0] : phaseTop[LUT_AW-1:0];
  assign scaled   = PROD_W'(magQ) * PROD_W'(amp) + HALF_LSB;
  assign rounded  = AMP_W'(scaled >> TBL_W);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      magQ      <= '0;
      negQ      <= 1'b0;
      sampleOut <= '0;
    end else begin
      if (strobes.stage1) begin
        magQ <= lut[addr];
        negQ <= phaseTop[LUT_AW+1];
      end
      if (strobes.stage2) begin
        sampleOut <= negQ ? -$signed({1'b0, rounded}) : $signed({1'b0, rounded});
      end
    end
  end
endmodule

// File: rtl/vhzDatapath.sv
module vhzDatapath import vhzPkg::*; #(
  parameter int ACC_W      = 24,
  parameter int FREQ_W     = 16,
  parameter int RATIO_W    = 16,
  parameter int RATIO_FRAC = 16,
  parameter int AMP_W      = 15,
  parameter int LUT_AW     = 8,
  parameter int TBL_W      = 16
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  vhzStrobes_t            strobes,
  input  logic [FREQ_W-1:0]      freqCmd,
  input  logic [RATIO_W-1:0]     vfRatio,
  input  logic [AMP_W-1:0]       ampLimit,
  output logic                   wrapNext,
  output logic                   incZero,
  output logic [FREQ_W-1:0]      incActive,
  output logic [AMP_W-1:0]       ampActive,
  output logic signed [AMP_W:0]  laneOut [3]
);
  localparam int PROD_W = FREQ_W + RATIO_W;
  localparam int SC_W   = PROD_W - RATIO_FRAC;
  localparam int CMP_W  = (SC_W > AMP_W) ? SC_W : AMP_W;
  localparam longint FULL_TURN = longint'(1) << ACC_W;

  logic [ACC_W-1:0]  acc;
  logic [ACC_W:0]    accSum;
  logic [PROD_W-1:0] volts;
  logic [CMP_W-1:0]  scaledAmp;
  logic [AMP_W-1:0]  ampTarget;

  assign accSum    = {1'b0, acc} + (ACC_W+1)'(incActive);
  assign wrapNext  = accSum[ACC_W];
  assign incZero   = (incActive == '0);
  assign volts     = PROD_W'(freqCmd) * PROD_W'(vfRatio);
  assign scaledAmp = CMP_W'(volts >> RATIO_FRAC);
  assign ampTarget = (scaledAmp > CMP_W'(ampLimit)) ? ampLimit : AMP_W'(scaledAmp);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      acc       <= '0;
      incActive <= '0;
      ampActive <= '0;
    end else begin
      if (strobes.advance) acc <= accSum[ACC_W-1:0];
      if (strobes.loadCmd) begin
        incActive <= freqCmd;
        ampActive <= ampTarget;
      end
    end
  end

  for (genvar g = 0; g < 3; g++) begin : g_lane
    localparam logic [ACC_W-1:0] OFFSET = ACC_W'((longint'(g) * FULL_TURN + 1) / 3);
    logic [ACC_W-1:0] lanePhase;
    assign lanePhase = acc - OFFSET;
    vhzSineLane #(
      .ACC_W(ACC_W), .LUT_AW(LUT_AW), .TBL_W(TBL_W), .AMP_W(AMP_W)
    ) u_lane (
      .clk(clk), .rstN(rstN), .strobes(strobes),
      .phase(lanePhase), .amp(ampActive), .sampleOut(laneOut[g])
    );
  end
endmodule

// File: rtl/vhzSineRef.sv
module vhzSineRef import vhzPkg::*; #(
  parameter int ACC_W      = 24,
  parameter int FREQ_W     = 16,
  parameter int RATIO_W    = 16,
  parameter int RATIO_FRAC = 16,
  parameter int AMP_W      = 15,
  parameter int LUT_AW     = 8,
  parameter int TBL_W      = 16,
  parameter int SAMPLE_DIV = 4
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [FREQ_W-1:0]     freqCmd,
  input  logic [RATIO_W-1:0]    vfRatio,
  input  logic [AMP_W-1:0]      ampLimit,
  output logic signed [AMP_W:0] phaseA,
  output logic signed [AMP_W:0] phaseB,
  output logic signed [AMP_W:0] phaseC,
  output logic                  sampleValid
);
  vhzStrobes_t strobes;
  logic wrapNext, incZero, loadCmd;
  logic [FREQ_W-1:0] incActive;
  logic [AMP_W-1:0]  ampActive;
  logic signed [AMP_W:0] laneOut [3];

  assign loadCmd = strobes.loadCmd;

  vhzCtrl #(.SAMPLE_DIV(SAMPLE_DIV)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrapNext(wrapNext), .incZero(incZero),
    .strobes(strobes), .sampleValid(sampleValid)
  );

  vhzDatapath #(
    .ACC_W(ACC_W), .FREQ_W(FREQ_W), .RATIO_W(RATIO_W), .RATIO_FRAC(RATIO_FRAC),
    .AMP_W(AMP_W), .LUT_AW(LUT_AW), .TBL_W(TBL_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .freqCmd(freqCmd), .vfRatio(vfRatio), .ampLimit(ampLimit),
    .wrapNext(wrapNext), .incZero(incZero),
    .incActive(incActive), .ampActive(ampActive), .laneOut(laneOut)
  );

  assign phaseA = laneOut[0];
  assign phaseB = laneOut[1];
  assign phaseC = laneOut[2];
endmodule

// File: rtl/vhzSineRef_checker.sv
module vhzSineRef_checker #(
  parameter int FREQ_W     = 16,
  parameter int AMP_W      = 15,
  parameter int SAMPLE_DIV = 4
) (
  input logic                  clk,
  input logic                  rstN,
  input logic                  sampleValid,
  input logic signed [AMP_W:0] phaseA,
  input logic signed [AMP_W:0] phaseB,
  input logic signed [AMP_W:0] phaseC,
  input logic [AMP_W-1:0]      ampActive,
  input logic [AMP_W-1:0]      ampLimit,
  input logic [FREQ_W-1:0]     incActive,
  input logic                  loadCmd
);
  function automatic int magOf(input logic signed [AMP_W:0] x);
    return (x < 0) ? -int'(x) : int'(x);
  endfunction

  function automatic int sumOf(input logic signed [AMP_W:0] a, b, c);
    int s;
    s = int'(a) + int'(b) + int'(c);
    return (s < 0) ? -s : s;
  endfunction

  int   gapCnt;
  logic seenValid;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      gapCnt    <= 0;
      seenValid <= 1'b0;
    end else if (sampleValid) begin
      gapCnt    <= 1;
      seenValid <= 1'b1;
    end else if (gapCnt < 1000) begin
      gapCnt <= gapCnt + 1;
    end
  end

  assert_valid_pulse_R2: assert property (@(posedge clk) disable iff (!rstN)
    sampleValid |=> !sampleValid);

  assert_valid_gap_R2: assert property (@(posedge clk) disable iff (!rstN)
    (sampleValid && seenValid) |-> (gapCnt == SAMPLE_DIV));

  assert_amp_clamp_R4: assert property (@(posedge clk) disable iff (!rstN)
    $past(loadCmd) |-> (ampActive <= $past(ampLimit)));

  assert_mag_bound_R5: assert property (@(posedge clk) disable iff (!rstN)
    sampleValid |-> (magOf(phaseA) <= int'(ampActive) && magOf(phaseB) <= int'(ampActive)
                     && magOf(phaseC) <= int'(ampActive)));

  assert_phase_sum_R6: assert property (@(posedge clk) disable iff (!rstN)
    sampleValid |-> (sumOf(phaseA, phaseB, phaseC) <= (int'(ampActive) >> 6) + 4));

  assert_amp_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(ampActive) |-> $past(loadCmd));

  assert_inc_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(incActive) |-> $past(loadCmd));
endmodule

bind vhzSineRef vhzSineRef_checker #(
  .FREQ_W(FREQ_W), .AMP_W(AMP_W), .SAMPLE_DIV(SAMPLE_DIV)
) u_checker (
  .clk(clk), .rstN(rstN), .sampleValid(sampleValid),
  .phaseA(phaseA), .phaseB(phaseB), .phaseC(phaseC),
  .ampActive(ampActive), .ampLimit(ampLimit), .incActive(incActive),
  .loadCmd(loadCmd)
);

// File: tb/vhzSineRef_bench.sv
module vhzSineRef_bench;
  localparam longint TURN  = longint'(1) << 24;
  localparam longint OFF_B = 5592405;
  localparam longint OFF_C = 11184811;
  localparam int     NVEC  = 8;
  // {freqCmd, vfRatio, ampLimit, expected amplitude}
  localparam logic [63:0] VEC [NVEC] = '{
    {16'd16384, 16'h8000, 16'd20000, 16'd8192},
    {16'd32768, 16'h8000, 16'd20000, 16'd16384},
    {16'd24576, 16'h8000, 16'd20000, 16'd12288},
    {16'd50000, 16'h8000, 16'd20000, 16'd20000},
    {16'd65535, 16'h8000, 16'd20000, 16'd20000},
    {16'd40000, 16'h6000, 16'd32767, 16'd15000},
    {16'd20000, 16'hC000, 16'd32767, 16'd15000},
    {16'd60000, 16'hC000, 16'd30000, 16'd30000}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [15:0] freqCmd = '0;
  logic [15:0] vfRatio = '0;
  logic [14:0] ampLimit = '0;
  logic signed [15:0] phaseA, phaseB, phaseC;
  logic sampleValid;

  int checks = 0, fails = 0;
  longint cycle = 0, lastValid = -1;
  longint modelAcc = 0, modelInc = 0, modelAmp = 0;
  int loadCount = 0, wrapCount = 0, sampleCount = 0;
  logic trackPeak = 1'b0;
  int peak = 0;
  logic signed [15:0] prevA = 0, prevB = 0, prevC = 0;
  logic done = 1'b0;

  always #10 clk = ~clk;

  vhzSineRef u_vhzSineRef (
    .clk(clk), .rstN(rstN), .freqCmd(freqCmd), .vfRatio(vfRatio), .ampLimit(ampLimit),
    .phaseA(phaseA), .phaseB(phaseB), .phaseC(phaseC), .sampleValid(sampleValid)
  );

  function automatic longint targetAmp(longint c, longint r, longint l);
    longint a;
    a = (c * r) >> 16;
    return (a > l) ? l : a;
  endfunction

  function automatic int ideal(longint ph, longint amp);
    longint k;
    real v;
    k = ph >> 14;
    v = real'(amp) * $sin(6.283185307179586 * (real'(k) + 0.5) / 1024.0);
    return (v >= 0.0) ? $rtoi(v + 0.5) : -$rtoi(-v + 0.5);
  endfunction

  function automatic int absI(int x);
    return (x < 0) ? -x : x;
  endfunction

  task automatic check(input logic ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic handleSample();
    longint nxt;
    logic pendingBefore;
    string tag;
    int eA, eB, eC;
    pendingBefore = (longint'(freqCmd) != modelInc) ||
                    (targetAmp(freqCmd, vfRatio, ampLimit) != modelAmp);
    if (lastValid >= 0)
      check(cycle - lastValid == 4, "R2", "valid spacing", int'(cycle - lastValid), 4);
    lastValid = cycle;
    sampleCount++;
    nxt = modelAcc + modelInc;
    if (nxt >= TURN) wrapCount++;
    if (nxt >= TURN || modelInc == 0) begin
      modelInc = freqCmd;
      modelAmp = targetAmp(freqCmd, vfRatio, ampLimit);
      loadCount++;
    end
    modelAcc = nxt % TURN;
    tag = pendingBefore ? "R7" : "R5";
    eA = ideal(modelAcc, modelAmp);
    eB = ideal((modelAcc - OFF_B + TURN) % TURN, modelAmp);
    eC = ideal((modelAcc - OFF_C + TURN) % TURN, modelAmp);
    check(absI(int'(phaseA) - eA) <= 2, tag, "phase A sample", phaseA, eA);
    check(absI(int'(phaseB) - eB) <= 2, "R6", "phase B sample", phaseB, eB);
    check(absI(int'(phaseC) - eC) <= 2, "R6", "phase C sample", phaseC, eC);
    check(absI(int'(phaseA) + int'(phaseB) + int'(phaseC)) <= int'(modelAmp >> 6) + 4,
          "R6", "three-phase sum", int'(phaseA) + int'(phaseB) + int'(phaseC), 0);
    if (trackPeak && absI(phaseA) > peak) peak = absI(phaseA);
  endtask

  task automatic stepCycle();
    @(negedge clk);
    cycle++;
    if (sampleValid) handleSample();
    else if (phaseA !== prevA || phaseB !== prevB || phaseC !== prevC)
      check(1'b0, "R2", "output moved without valid", phaseA, prevA);
    prevA = phaseA; prevB = phaseB; prevC = phaseC;
  endtask

  task automatic checkResetState(input string when);
    check(phaseA == 0 && phaseB == 0 && phaseC == 0, "R1", {"outputs zero ", when},
          int'(phaseA) | int'(phaseB) | int'(phaseC), 0);
    check(sampleValid == 1'b0, "R1", {"valid low ", when}, sampleValid, 0);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    checkResetState("at start");
    // first vector applied during reset; loads on first sample (stopped)
    {freqCmd, vfRatio, ampLimit} = {VEC[0][63:48], VEC[0][47:32], VEC[0][30:16]};
    rstN = 1'b1;

    // Vector walk: linearity below the knee (R3), clamp above it (R4)
    for (int v = 0; v < NVEC; v++) begin
      int startLoads, startWraps;
      int expAmp;
      logic clamped;
      freqCmd  = VEC[v][63:48];
      vfRatio  = VEC[v][47:32];
      ampLimit = VEC[v][30:16];
      expAmp   = int'(VEC[v][15:0]);
      clamped  = ((longint'(freqCmd) * longint'(vfRatio)) >> 16) > longint'(ampLimit);
      startLoads = loadCount;
      while (loadCount == startLoads) stepCycle();
      trackPeak = 1'b1; peak = 0;
      startWraps = wrapCount;
      while (wrapCount == startWraps) stepCycle();
      trackPeak = 1'b0;
      check(absI(peak - expAmp) <= 2, clamped ? "R4" : "R3", "peak amplitude", peak, expAmp);
    end

    // R7: zero command stops at next rollover, output collapses to zero
    begin
      int startLoads, s;
      freqCmd = 16'd0;
      startLoads = loadCount;
      while (loadCount == startLoads) stepCycle();
      for (int n = 0; n < 6; n++) begin
        stepCycle();
        if (sampleValid)
          check(phaseA == 0 && phaseB == 0 && phaseC == 0, "R7", "stopped output zero", phaseA, 0);
      end
      while (!sampleValid) stepCycle();
      // R7: while stopped, a new command is taken on the very next sample
      freqCmd = 16'd16384; vfRatio = 16'h8000; ampLimit = 15'd20000;
      s = sampleCount; startLoads = loadCount;
      while (loadCount == startLoads) stepCycle();
      check(sampleCount - s == 1, "R7", "samples to restart when stopped", sampleCount - s, 1);
      for (int n = 0; n < 400; n++) stepCycle();
    end

    // R1: reset in the middle of a run
    @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    checkResetState("after mid-run reset");
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule